// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked client and an asynchronous static RAM of 65,536 words by 24 bits. The client hands over one word-sized read or write at a time on a valid/ready handshake. The sequencer turns each request into a timed pattern of chip-select, output-enable and write-enable strobes. It also drives the tri-state data bus through separate out, in and enable signals. Read data returns with a single-cycle valid pulse. Every interval is a whole number of clock cycles, and a parameter sets each interval.

The RAM takes its sixteen-bit address as fifteen direct lines plus one top bit. The top bit can enter the part on either of two pins, and a source-select line chooses which pin the part uses. The client picks the path for each request. The sequencer drives both pins and the select line, and it holds the pin that is not in use at zero. The part has a chip select of each polarity. The sequencer asserts both during an access and releases both when idle. Writes always run with output enable held high, so the shorter write pulse applies.

After a read, the next write waits behind a turnaround gap. During the gap the chip is deselected and output enable is high, so the RAM releases the bus before the sequencer drives it.

Top module: `asram_sequencer`

## Requirements
- R1: Out of reset and whenever `req_ready_o` is high, the RAM is idle. This means `mem_cs_n_o`=1, `mem_cs_o`=0, `mem_oe_n_o`=1, `mem_we_n_o`=1 and `mem_dq_oe_o`=0. `rsp_valid_o` is 0 after reset.
- R2: While the chip is selected, `mem_addr_o` carries request address bits 14..0 and holds steady. When `req_alt_i`=0, `mem_top_sel_o`=0, `mem_top_o` carries address bit 15 and `mem_top_alt_o`=0. When `req_alt_i`=1, `mem_top_sel_o`=1, `mem_top_alt_o` carries bit 15 and `mem_top_o`=0. Both paths reach the same word.
- R3: During a write, `mem_we_n_o` is low for exactly the effective strobe count of cycles, with both chip selects asserted. `mem_oe_n_o` stays high for the whole write, and the word is stored at the addressed location.
- R4: A read holds `mem_we_n_o` high and `mem_oe_n_o` low for the setup plus strobe cycles. The data bus is captured on the last strobe cycle. `rsp_valid_o` pulses for one cycle, in the cycle after that capture, and carries the word.
- R5: `mem_dq_oe_o` is high only while `mem_we_n_o` is low. It is never high while `mem_oe_n_o` is low.
- R6: An access keeps the chip selected for setup cycles before the strobe, then strobe cycles. Recovery cycles follow with the chip deselected. `req_ready_o` stays low for the sum of these counts.
- R7: A count parameter set to 0 behaves exactly as a count of 1.
- R8: A write that directly follows a read is preceded by the turnaround count of cycles, with the chip deselected and `mem_oe_n_o` high. No gap is inserted for any other pair of accesses.
- R9: `req_ready_o` falls in the cycle after acceptance and stays low until the access ends. A write produces no `rsp_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request taken on valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_alt_i | input | 1 | 1 = top address bit on the alternate pin |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | DATA_W | Read data |
| mem_addr_o | output | ADDR_W-1 | Direct address lines |
| mem_top_o | output | 1 | Top address bit, direct pin |
| mem_top_alt_o | output | 1 | Top address bit, alternate pin |
| mem_top_sel_o | output | 1 | Top-bit source select (1 = alternate) |
| mem_cs_n_o | output | 1 | Active-low chip select |
| mem_cs_o | output | 1 | Active-high chip select |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_dq_o | output | DATA_W | Data bus, outgoing |
| mem_dq_i | input | DATA_W | Data bus, incoming |
| mem_dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with `SETUP_CYC`=0, `TURN_CYC`=0, `STROBE_CYC`=3 and `RECOV_CYC`=2. The two zero settings bring the clamp to one cycle within reach, for both setup and turnaround. The three-cycle strobe makes the pulse width measurable, since an off-by-one in the count would show. The two-cycle recovery separates the read-valid pulse from the return of ready. A behavioural RAM model decodes the top bit through whichever pin the select line names. This lets the bench write a word through one path and read it back through the other.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_STROBE,
        ST_RECOV
    } seq_state_e;

    typedef struct packed {
        logic wr;
        logic alt;
    } req_ctl_t;

    typedef struct packed {
        logic cs_n;
        logic cs;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STB_IDLE = '{cs_n: 1'b1, cs: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    function automatic int clamp1(input int n);
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/seq_addr_route.sv
module seq_addr_route #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              alt,
    output logic [ADDR_W-2:0] low,
    output logic              top_direct,
    output logic              top_alt,
    output logic              sel
);
    assign low        = addr[ADDR_W-2:0];
    assign sel        = alt;
    assign top_direct = alt ? 1'b0 : addr[ADDR_W-1];
    assign top_alt    = alt ? addr[ADDR_W-1] : 1'b0;
endmodule

// File: rtl/seq_strobe_decode.sv
module seq_strobe_decode
    import sram_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic       wr,
    output strobe_t    stb
);
    always_comb begin
        stb = STB_IDLE;
        unique case (state)
            ST_SETUP: begin
                stb.cs_n = 1'b0;
                stb.cs   = 1'b1;
                stb.oe_n = wr;
            end
            ST_STROBE: begin
                stb.cs_n  = 1'b0;
                stb.cs    = 1'b1;
                stb.oe_n  = wr;
                stb.we_n  = ~wr;
                stb.dq_oe = wr;
            end
            default: stb = STB_IDLE;
        endcase
    end
endmodule

// File: rtl/seq_read_capture.sv
module seq_read_capture #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= capture;
            if (capture)
                data <= dq_in;
        end
    end
endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 24,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int RECOV_CYC  = 1,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic              req_alt_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic [ADDR_W-2:0] mem_addr_o,
    output logic              mem_top_o,
    output logic              mem_top_alt_o,
    output logic              mem_top_sel_o,
    output logic              mem_cs_n_o,
    output logic              mem_cs_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe_o
);
    localparam int S_EFF = clamp1(SETUP_CYC);
    localparam int P_EFF = clamp1(STROBE_CYC);
    localparam int R_EFF = clamp1(RECOV_CYC);
    localparam int T_EFF = clamp1(TURN_CYC);
    localparam int MAXC  = max2(max2(S_EFF, P_EFF), max2(R_EFF, T_EFF));
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] S_LD = CNT_W'(S_EFF - 1);
    localparam logic [CNT_W-1:0] P_LD = CNT_W'(P_EFF - 1);
    localparam logic [CNT_W-1:0] R_LD = CNT_W'(R_EFF - 1);
    localparam logic [CNT_W-1:0] T_LD = CNT_W'(T_EFF - 1);

    seq_state_e        state_q, state_d;
    req_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              last_rd_q;
    logic              tmr_load, tmr_last;
    logic [CNT_W-1:0]  tmr_val;
    logic              accept;
    strobe_t           stb;

    assign req_ready_o = (state_q == ST_IDLE);
    assign accept      = req_ready_o && req_valid_i;

    // Phase sequencing: each phase loads the timer with its count minus one.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid_i) begin
                tmr_load = 1'b1;
                if (req_write_i && last_rd_q) begin
                    state_d = ST_TURN;
                    tmr_val = T_LD;
                end else begin
                    state_d = ST_SETUP;
                    tmr_val = S_LD;
                end
            end
            ST_TURN: if (tmr_last) begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = S_LD;
            end
            ST_SETUP: if (tmr_last) begin
                state_d  = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = P_LD;
            end
            ST_STROBE: if (tmr_last) begin
                state_d  = ST_RECOV;
                tmr_load = 1'b1;
                tmr_val  = R_LD;
            end
            ST_RECOV: if (tmr_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctl_q     <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ctl_q.wr  <= req_write_i;
                ctl_q.alt <= req_alt_i;
                addr_q    <= req_addr_i;
                wdata_q   <= req_wdata_i;
            end
            if (state_q == ST_STROBE && tmr_last)
                last_rd_q <= ~ctl_q.wr;
        end
    end

    seq_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    seq_addr_route #(.ADDR_W(ADDR_W)) u_route (
        .addr       (addr_q),
        .alt        (ctl_q.alt),
        .low        (mem_addr_o),
        .top_direct (mem_top_o),
        .top_alt    (mem_top_alt_o),
        .sel        (mem_top_sel_o)
    );

    seq_strobe_decode u_decode (
        .state (state_q),
        .wr    (ctl_q.wr),
        .stb   (stb)
    );

    seq_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .capture (state_q == ST_STROBE && tmr_last && !ctl_q.wr),
        .dq_in   (mem_dq_i),
        .valid   (rsp_valid_o),
        .data    (rsp_rdata_o)
    );

    assign mem_cs_n_o  = stb.cs_n;
    assign mem_cs_o    = stb.cs;
    assign mem_oe_n_o  = stb.oe_n;
    assign mem_we_n_o  = stb.we_n;
    assign mem_dq_oe_o = stb.dq_oe;
    assign mem_dq_o    = wdata_q;
endmodule

// File: rtl/sram_seq_checker.sv
module sram_seq_checker #(
    parameter int AW = 15
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_cs,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R2
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R3
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_cs)); // R3
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R4
    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n); // R5
    AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n); // R5
    AST_RVALID_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready); // R9
endmodule

bind asram_sequencer sram_seq_checker #(.AW(ADDR_W-1)) u_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready_o),
    .rsp_valid (rsp_valid_o),
    .mem_addr  (mem_addr_o),
    .mem_cs_n  (mem_cs_n_o),
    .mem_cs    (mem_cs_o),
    .mem_oe_n  (mem_oe_n_o),
    .mem_we_n  (mem_we_n_o),
    .mem_dq_oe (mem_dq_oe_o)
);

// File: tb/asram_sequencer_bench.sv
module asram_sequencer_bench;
    localparam int AW = 16;
    localparam int DW = 24;
    localparam logic [DW-1:0] IDLE_BUS = 24'h5A5A5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0, req_alt = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-2:0] mem_addr;
    logic          mem_top, mem_top_alt, mem_top_sel;
    logic          mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i = IDLE_BUS;

    asram_sequencer #(
        .ADDR_W(AW), .DATA_W(DW),
        .SETUP_CYC(0), .STROBE_CYC(3), .RECOV_CYC(2), .TURN_CYC(0)
    ) u_asram_sequencer (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_write_i(req_write), .req_alt_i(req_alt),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .mem_addr_o(mem_addr), .mem_top_o(mem_top),
        .mem_top_alt_o(mem_top_alt), .mem_top_sel_o(mem_top_sel),
        .mem_cs_n_o(mem_cs_n), .mem_cs_o(mem_cs),
        .mem_oe_n_o(mem_oe_n), .mem_we_n_o(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe_o(mem_dq_oe)
    );

    // Behavioural RAM: top bit taken from whichever pin the select line names.
    logic [DW-1:0] ram [int unsigned];
    wire            selected = !mem_cs_n && mem_cs;
    wire [AW-1:0]   full_addr = {(mem_top_sel ? mem_top_alt : mem_top), mem_addr};

    always @(negedge clk) begin
        if (selected && !mem_we_n)
            ram[int'(full_addr)] = mem_dq_o;
        if (selected && !mem_oe_n && mem_we_n)
            mem_dq_i <= ram.exists(int'(full_addr)) ? ram[int'(full_addr)] : '0;
        else
            mem_dq_i <= IDLE_BUS;
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Measured properties of one access
    int  m_busy, m_we_low, m_oe_low, m_sel, m_sel_pre_we, m_lead, m_rv, m_rv_idx;
    int  m_addr_bad, m_drive_bad, m_path_bad;
    bit  m_ready_first;
    logic [DW-1:0] m_rdata;

    task automatic access(input bit wr, input bit alt, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
        int  idx;
        bit  seen_sel, seen_we;
        m_busy = 0; m_we_low = 0; m_oe_low = 0; m_sel = 0; m_sel_pre_we = 0;
        m_lead = 0; m_rv = 0; m_rv_idx = 0; m_addr_bad = 0; m_drive_bad = 0;
        m_path_bad = 0; m_rdata = '0; seen_sel = 0; seen_we = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_alt = alt; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        m_ready_first = req_ready;
        idx = 1;
        while (!req_ready && idx < 64) begin
            if (selected) begin
                seen_sel = 1;
                m_sel++;
                if (!seen_we && mem_we_n) m_sel_pre_we++;
                if (mem_addr != a[AW-2:0]) m_addr_bad++;
                if (mem_top_sel != alt) m_path_bad++;
                if (alt && (mem_top_alt != a[AW-1] || mem_top != 1'b0)) m_path_bad++;
                if (!alt && (mem_top != a[AW-1] || mem_top_alt != 1'b0)) m_path_bad++;
            end else if (!seen_sel) begin
                m_lead++;
                if (!mem_oe_n) m_drive_bad++;
            end
            if (!mem_we_n) begin m_we_low++; seen_we = 1; end
            if (!mem_oe_n) m_oe_low++;
            if (mem_dq_oe && (mem_we_n || !mem_oe_n)) m_drive_bad++;
            if (rsp_valid) begin m_rv++; m_rv_idx = idx; m_rdata = rsp_rdata; end
            @(negedge clk);
            idx++;
        end
        m_busy = idx - 1;
        if (rsp_valid) m_rv++;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk({mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe} == 5'b10110,
            "R1 idle strobes", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    endtask

    task automatic t_write(input bit alt, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int exp_lead);
        access(1'b1, alt, a, d);
        chk(m_ready_first == 1'b0, "R9 ready drops after accept", m_ready_first, 0);
        chk(m_busy == 6 + exp_lead, "R6 write busy length", m_busy, 6 + exp_lead);
        chk(m_we_low == 3, "R3 write pulse width", m_we_low, 3);
        chk(m_oe_low == 0, "R3 oe high during write", m_oe_low, 0);
        chk(m_sel == 4, "R6 selected cycles", m_sel, 4);
        chk(m_sel_pre_we == 1, "R7 zero setup clamped to one", m_sel_pre_we, 1);
        chk(m_lead == exp_lead, "R8 turnaround gap", m_lead, exp_lead);
        chk(m_drive_bad == 0, "R5 bus drive window", m_drive_bad, 0);
        chk(m_addr_bad == 0, "R2 low address lines", m_addr_bad, 0);
        chk(m_path_bad == 0, "R2 top bit path", m_path_bad, 0);
        chk(m_rv == 0, "R9 no response for write", m_rv, 0);
        chk(ram.exists(int'(a)) && ram[int'(a)] == d, "R3 word stored",
            ram.exists(int'(a)) ? ram[int'(a)] : 0, d);
    endtask

    task automatic t_read(input bit alt, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        access(1'b0, alt, a, '0);
        chk(m_busy == 6, "R6 read busy length", m_busy, 6);
        chk(m_lead == 0, "R8 no gap before read", m_lead, 0);
        chk(m_oe_low == 4, "R4 oe low window", m_oe_low, 4);
        chk(m_we_low == 0, "R4 we high during read", m_we_low, 0);
        chk(m_rv == 1 && m_rv_idx == 5, "R4 response pulse timing", m_rv_idx, 5);
        chk(m_rdata == exp, "R4 read data", m_rdata, exp);
        chk(m_addr_bad == 0 && m_path_bad == 0, "R2 read address", m_addr_bad + m_path_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write(1'b0, 16'h1234, 24'hA1B2C3, 0);
        t_write(1'b0, 16'h0000, 24'h000001, 0);   // write after write: no gap (R8)
        t_read (1'b0, 16'h1234, 24'hA1B2C3);
        t_write(1'b1, 16'h8001, 24'h55AA33, 1);   // write after read: gap (R8), alt path
        t_read (1'b0, 16'h8001, 24'h55AA33);      // same word via direct path (R2)
        t_write(1'b0, 16'h0005, 24'h111111, 1);
        t_write(1'b1, 16'h8005, 24'h222222, 0);
        t_read (1'b1, 16'h0005, 24'h111111);      // top bit separates words (R2)
        t_read (1'b0, 16'h8005, 24'h222222);      // read after read: no gap (R8)
        t_write(1'b0, 16'hFFFF, 24'hFFFFFE, 1);
        t_read (1'b1, 16'hFFFF, 24'hFFFFFE);
        t_read (1'b0, 16'h0000, 24'h000001);
        @(negedge clk);
        t_reset();
        finish_run();
    end
endmodule